// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a slave on a two-wire serial bus. It gives a bus host access to a small bank of byte registers. The bank itself sits outside the block, on a plain port that carries an address, write data, a write strobe and read data. The bus lines are sampled in the system clock domain through two-flop synchronisers. START and STOP conditions are recognised on the synchronised samples. The block answers only to one fixed 7-bit device address and pulls SDA low only through an open-drain output enable.

A write transfer is made of the device address, then one pointer byte, then any number of data bytes. Each data byte goes to the register the pointer selects. A read transfer returns the register at the pointer, MSB first, for as long as the host acknowledges. The pointer advances after every data byte in either direction and wraps at the end of the bank. A repeated START keeps the pointer, so the usual "set pointer, then read" sequence works. A power-fail input aborts any transfer at once, clears the pointer and makes the block ignore the bus while it is high.

Top module: `i2c_regbank_slave`

## Requirements
- R1: Only an address byte equal to D0h (write) or D1h (read), R/W in bit 0, is acknowledged. After any other address the block drives nothing and writes nothing until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After STOP the block ignores clock pulses until a new START.
- R3: Bytes are 8 bits, MSB first. After an accepted address byte or written byte, the block holds SDA low for the whole ninth clock.
- R4: In a write, the first byte after the address loads the pointer from its low 3 bits. Each later byte is written with a single-cycle reg_we at the pointer value.
- R5: The pointer advances by one after every data byte written or read, and it wraps from 7 to 0.
- R6: In a read, each byte sent is the reg_rdata at the pointer, MSB first, and the read goes on while the host acknowledges.
- R7: When the host does not acknowledge a read byte, the block releases SDA and drives nothing more in that transfer.
- R8: A repeated START restarts address matching and leaves the pointer unchanged.
- R9: While pwr_fail is high, the transfer ends at once, the pointer becomes 0, sda_oe stays low and bus activity is ignored.
- R10: SDA is only ever pulled low through sda_oe. sda_oe changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Power-fail abort, synchronous to clk |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 3 | Register bank address (the pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Register bank read data at reg_addr |

## Verification
A wrong internal state shows at the ports within one bus byte:
- A wrong pointer shows on reg_addr straight away, and it shows in the next byte read or written.
- A wrong phase or bit count shifts the acknowledge by a bit, or drops it. The host sees this on the ninth clock of that byte.
- A block that failed to return to idle after STOP, a NACK or a power-fail would answer clocks it should ignore. That answer shows on SDA on the very next byte.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_ACK_WAIT,
    PH_ACK_OUT,
    PH_TX,
    PH_ACK_IN
  } phase_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_PTR,
    BK_DATA
  } kind_t;

  // device address match on the upper seven bits of the address byte
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // pointer successor with wrap at the bank depth
  function automatic int unsigned ptr_after(input int unsigned p, input int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/regslv_sync.sv
module regslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_hi,
  output logic sda_hi,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] now;
  logic [LINES-1:0] last;

  assign raw = {sda_raw, scl_raw};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign now[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= '1;
    else        last <= now;
  end

  assign scl_hi    = now[0];
  assign sda_hi    = now[1];
  assign scl_rise  = now[0] & ~last[0];
  assign scl_fall  = ~now[0] & last[0];
  assign start_evt = now[0] & last[0] & last[1] & ~now[1];
  assign stop_evt  = now[0] & last[0] & ~last[1] & now[1];

  // R2: a bus condition can only be seen with SCL steady high
  a_r2_cond_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |-> ($past(scl_hi) && scl_hi));

endmodule

// File: rtl/regslv_ptr.sv
module regslv_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             inc,
  output logic [PTR_W-1:0] ptr
);
  import regslv_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr <= '0;
    else if (clr)   ptr <= '0;
    else if (load)  ptr <= load_val;
    else if (inc)   ptr <= PTR_W'(ptr_after(32'(ptr), DEPTH));
  end

  // R5: the last register is followed by register 0
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && !load && ptr == PTR_W'(DEPTH-1)) |=> ptr == '0);

  // R9: a clear always leaves the pointer at 0
  a_r9_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr == '0);

endmodule

// File: rtl/regslv_fsm.sv
module regslv_fsm #(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         PTR_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_fail,
  input  logic             scl_hi,
  input  logic             sda_hi,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rdata,
  output logic             sda_oe,
  output logic             ptr_load,
  output logic [PTR_W-1:0] ptr_load_val,
  output logic             ptr_inc,
  output logic             we,
  output logic [7:0]       wdata
);
  import regslv_pkg::*;

  phase_t     phase;
  kind_t      kind;
  logic [2:0] bitcnt;
  logic [7:0] shreg;
  logic       rw;
  logic       mack;
  logic       live;
  logic       byte_done;
  logic [7:0] rx_byte;

  assign live      = !pwr_fail && !start_evt && !stop_evt;
  assign rx_byte   = {shreg[6:0], sda_hi};
  assign byte_done = live && phase == PH_RX && scl_rise && bitcnt == 3'd7;

  assign ptr_load     = byte_done && kind == BK_PTR;
  assign ptr_load_val = rx_byte[PTR_W-1:0];
  assign ptr_inc      = live && scl_fall &&
                        ((phase == PH_ACK_OUT && kind == BK_DATA) ||
                         (phase == PH_TX && bitcnt == 3'd7));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      kind   <= BK_ADDR;
      bitcnt <= '0;
      shreg  <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      we     <= 1'b0;
      wdata  <= '0;
    end else if (pwr_fail) begin
      phase  <= PH_IDLE;
      sda_oe <= 1'b0;
      we     <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_evt) begin
        phase  <= PH_RX;
        kind   <= BK_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (phase)
          PH_RX: if (scl_rise) begin
            shreg <= rx_byte;
            if (bitcnt == 3'd7) begin
              bitcnt <= '0;
              case (kind)
                BK_ADDR: begin
                  if (addr_hit(rx_byte, DEV_ADDR)) begin
                    rw    <= rx_byte[0];
                    phase <= PH_ACK_WAIT;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                BK_PTR: phase <= PH_ACK_WAIT;
                default: begin
                  we    <= 1'b1;
                  wdata <= rx_byte;
                  phase <= PH_ACK_WAIT;
                end
              endcase
            end else begin
              bitcnt <= bitcnt + 3'd1;
            end
          end
          PH_ACK_WAIT: if (scl_fall) begin
            sda_oe <= 1'b1;
            phase  <= PH_ACK_OUT;
          end
          PH_ACK_OUT: if (scl_fall) begin
            bitcnt <= '0;
            if (kind == BK_ADDR && rw) begin
              kind   <= BK_DATA;
              phase  <= PH_TX;
              shreg  <= rdata;
              sda_oe <= ~rdata[7];
            end else begin
              kind   <= (kind == BK_ADDR) ? BK_PTR : BK_DATA;
              phase  <= PH_RX;
              sda_oe <= 1'b0;
            end
          end
          PH_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;
              phase  <= PH_ACK_IN;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
              bitcnt <= bitcnt + 3'd1;
            end
          end
          PH_ACK_IN: begin
            if (scl_rise) mack <= ~sda_hi;
            if (scl_fall) begin
              bitcnt <= '0;
              if (mack) begin
                phase  <= PH_TX;
                shreg  <= rdata;
                sda_oe <= ~rdata[7];
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end
    end
  end

  // R10: the output enable never moves while SCL stays high
  a_r10_oe_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hi && $past(scl_hi) && !pwr_fail && !$past(pwr_fail) && !start_evt)
      |-> $stable(sda_oe));

  // R1: an idle slave drives nothing
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> !sda_oe);

  // R4: a register write is a single-cycle strobe
  a_r4_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  // R9: power-fail forces the bus interface quiet on the next cycle
  a_r9_pf_abort: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (!sda_oe && !we && phase == PH_IDLE));

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         DEPTH       = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_fail,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);

  logic             scl_hi, sda_hi, scl_rise, scl_fall, start_evt, stop_evt;
  logic             ptr_load, ptr_inc;
  logic [PTR_W-1:0] ptr_load_val;

  regslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_raw   (scl_i),
    .sda_raw   (sda_i),
    .scl_hi    (scl_hi),
    .sda_hi    (sda_hi),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  regslv_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwr_fail     (pwr_fail),
    .scl_hi       (scl_hi),
    .sda_hi       (sda_hi),
    .scl_rise     (scl_rise),
    .scl_fall     (scl_fall),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .rdata        (reg_rdata),
    .sda_oe       (sda_oe),
    .ptr_load     (ptr_load),
    .ptr_load_val (ptr_load_val),
    .ptr_inc      (ptr_inc),
    .we           (reg_we),
    .wdata        (reg_wdata)
  );

  regslv_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (pwr_fail),
    .load     (ptr_load),
    .load_val (ptr_load_val),
    .inc      (ptr_inc),
    .ptr      (reg_addr)
  );

  // R4: the write address is held steady through the strobe
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !pwr_fail) |=> $stable(reg_addr));

endmodule

// File: tb/tb_i2c_regbank_slave.sv
module tb_i2c_regbank_slave;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_fail = 1'b0;
  logic       m_scl = 1'b1;
  logic       m_low = 1'b0;
  logic       sda_line;
  logic       sda_oe;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       reg_we;
  logic [7:0] reg_rdata;
  logic [7:0] bank [8];
  logic [7:0] expv [8];
  int         n_run = 0;
  int         n_fail = 0;

  always #5 clk = ~clk;

  assign sda_line  = ~(m_low | sda_oe);
  assign reg_rdata = bank[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) bank[i] <= 8'h40 + 8'(i);
    end else if (reg_we) begin
      bank[reg_addr] <= reg_wdata;
    end
  end

  i2c_regbank_slave dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_fail  (pwr_fail),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; w(Q);
    m_scl = 1'b1; w(Q);
    m_low = 1'b1; w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; w(Q);
    m_scl = 1'b1; w(Q);
    m_low = 1'b0; w(Q);
  endtask

  task automatic put_bit(input logic b);
    m_low = ~b; w(Q);
    m_scl = 1'b1; w(2*Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    m_low = 1'b0; w(Q);
    m_scl = 1'b1; w(Q);
    b = sda_line; w(Q);
    m_scl = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic get_byte(input logic host_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~host_ack);
  endtask

  task automatic chk_bank(input string req);
    for (int i = 0; i < 8; i++) chk(req, bank[i], expv[i]);
  endtask

  task automatic t_reset();
    chk("R10 reset oe", sda_oe, 0);
    chk("R5 reset ptr", reg_addr, 0);
    chk("R4 reset we", reg_we, 0);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start();
    put_byte(8'hA0, a);
    chk("R1 foreign addr nack", a, 0);
    put_byte(8'h5A, a);
    chk("R1 no ack after foreign addr", a, 0);
    bus_stop();
    chk_bank("R1 bank untouched");
    chk("R1 ptr untouched", reg_addr, 0);
  endtask

  task automatic t_write_burst();
    logic a;
    bus_start();
    put_byte(8'hD0, a); chk("R3 addr ack", a, 1);
    put_byte(8'h05, a); chk("R3 ptr ack", a, 1);
    chk("R4 ptr loaded", reg_addr, 5);
    put_byte(8'h11, a); chk("R3 data ack", a, 1);
    put_byte(8'h22, a);
    put_byte(8'h33, a);
    put_byte(8'h44, a); chk("R3 data ack after wrap", a, 1);
    bus_stop();
    expv[5] = 8'h11; expv[6] = 8'h22; expv[7] = 8'h33; expv[0] = 8'h44;
    chk_bank("R4 R5 burst write");
    chk("R5 ptr after wrap", reg_addr, 1);
  endtask

  task automatic t_read_rs();
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte(8'hD0, a);
    put_byte(8'h02, a);
    bus_start();
    chk("R8 ptr kept over restart", reg_addr, 2);
    put_byte(8'hD1, a); chk("R8 read addr ack", a, 1);
    get_byte(1'b1, v); chk("R6 read byte 0", v, expv[2]);
    get_byte(1'b1, v); chk("R6 read byte 1", v, expv[3]);
    get_byte(1'b0, v); chk("R6 read byte 2", v, expv[4]);
    get_byte(1'b0, v); chk("R7 released after nack", v, 8'hFF);
    bus_stop();
    chk("R5 ptr after read", reg_addr, 5);
  endtask

  task automatic t_read_wrap();
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte(8'hD0, a);
    put_byte(8'h07, a);
    bus_start();
    put_byte(8'hD1, a);
    get_byte(1'b1, v); chk("R5 read at 7", v, expv[7]);
    get_byte(1'b0, v); chk("R5 read wraps to 0", v, expv[0]);
    bus_stop();
    chk("R5 ptr after read wrap", reg_addr, 1);
    bus_start();
    put_byte(8'hD1, a); chk("R6 current read ack", a, 1);
    get_byte(1'b0, v); chk("R6 current address read", v, expv[1]);
    bus_stop();
  endtask

  task automatic t_after_stop();
    logic a;
    put_byte(8'hD0, a); chk("R2 no ack without start", a, 0);
    put_byte(8'h99, a); chk("R2 still idle", a, 0);
    chk_bank("R2 bank untouched");
    bus_start();
    put_byte(8'hD0, a); chk("R2 start after stop works", a, 1);
    bus_stop();
  endtask

  task automatic t_pwr_fail();
    logic a;
    logic [7:0] v;
    bus_start();
    put_byte(8'hD0, a);
    put_byte(8'h03, a);
    chk("R9 ptr set before abort", reg_addr, 3);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    pwr_fail = 1'b1;
    w(3);
    chk("R9 ptr cleared", reg_addr, 0);
    chk("R9 oe released", sda_oe, 0);
    bus_start();
    put_byte(8'hD0, a); chk("R9 bus ignored", a, 0);
    bus_stop();
    pwr_fail = 1'b0;
    w(Q);
    chk_bank("R9 partial byte dropped");
    bus_start();
    put_byte(8'hD1, a); chk("R9 ack after recovery", a, 1);
    get_byte(1'b0, v); chk("R9 read from 0", v, expv[0]);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) expv[i] = 8'h40 + 8'(i);
    w(5);
    rst_n = 1'b1;
    w(5);
    t_reset();
    t_bad_addr();
    t_write_burst();
    t_read_rs();
    t_read_wrap();
    t_after_stop();
    t_pwr_fail();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule